// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scan Driver

This block lights a row of common-cathode seven-segment displays that share a single 8-line anode bus: seven segments and a decimal point. Each display has its own cathode select, and only one display glows at a time. A write port holds one segment pattern per digit. The block steps through the digits in a fixed cycle. It gives each digit a programmable number of clock cycles, then moves to the next. Because the cycle repeats quickly, the eye sees all digits lit at once.

Between two digits the driver inserts exactly one dark cycle with every cathode released. During that cycle the anode bus is already loaded with the next digit's pattern. The new cathode is pulled low only after this, so a stale pattern never appears on the wrong display. The dwell length is a parameter. Its default suits a 50 MHz clock with four digits and gives a full scan rate far above the flicker threshold.

Top module: `seg_scan_driver`

## Requirements
- R1: While reset is asserted, every cathode line is HIGH, the anode bus is all zeros and every stored digit pattern is cleared to zero.
- R2: On the first cycle after reset release, the anode bus carries digit 0's pattern and all cathodes are HIGH. From the second cycle, cathode 0 is LOW.
- R3: At most one cathode line is LOW at any time. Cathode bit i belongs to digit i, and LOW means lit.
- R4: Each digit stays lit for exactly DWELL_CYCLES consecutive clock cycles.
- R5: Between two lit digits there is exactly one cycle with all cathodes HIGH. During that cycle the anode bus already carries the next digit's pattern. A cathode never moves directly from one digit to another.
- R6: Digits are lit in the order 0, 1, …, NUM_DIGITS-1, and then the scan wraps back to 0 with no end.
- R7: The anode bus does not change while any cathode is LOW.
- R8: A write (wrEn HIGH, wrAddr selects the digit, wrData the pattern) may come at any time. A write to the digit that is currently lit leaves the bus unchanged until that digit is next scanned, and from then on the new pattern shows.
- R9: Segment drive is active-high and passed through unchanged: wrData bit 0 goes to segment a, bits 1 to 6 go to b to g, and bit 7 goes to the decimal point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Pattern write strobe |
| wrAddr | input | IDX_W | Digit index of the write |
| wrData | input | SEG_W | Segment pattern, bit 0 = a, bit 7 = decimal point |
| segOut | output | SEG_W | Shared anode bus, active high |
| cathN | output | NUM_DIGITS | Per-digit cathode selects, active low |

## Verification
All outputs are registered. The pattern of digit 0 appears one cycle after reset release, and its cathode drops one cycle after that. After that, each digit holds for DWELL_CYCLES cycles and is followed by one dark cycle, so a digit period is DWELL_CYCLES+1 cycles. A write sampled on a clock edge reaches the bus only at the next load edge of its digit. A write on the same edge as that load is too late for this scan. The bench counts edges since reset release. Its expected model takes each pattern at the load edge, before that edge's write is applied. It samples 1 ns after each rising edge and drives inputs on falling edges.

// File: rtl/segscan_pkg.sv
`timescale 1ns/1ps
package segscan_pkg;

  // strobes from the scan control to the output datapath
  typedef struct packed {
    logic loadSeg;   // capture the selected digit's pattern onto the bus
    logic lightOn;   // pull the selected digit's cathode low
    logic darkOn;    // release every cathode
  } scanStrobe_t;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,  // first cycle after reset: load digit 0
    ST_BLANK = 2'd1,  // all dark, bus already holds the next pattern
    ST_LIT   = 2'd2   // one cathode low, dwell counting
  } scanState_t;

endpackage

// File: rtl/segscan_ctrl.sv
`timescale 1ns/1ps
module segscan_ctrl
  import segscan_pkg::*;
#(
  parameter int NUM_DIGITS   = 4,
  parameter int DWELL_CYCLES = 50000,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output scanStrobe_t      strobe,
  output logic [IDX_W-1:0] selIdx
);

  scanState_t       state;
  logic [IDX_W-1:0] scanIdx;
  logic [IDX_W-1:0] nextIdx;
  logic [CNT_W-1:0] dwellCnt;
  logic             lastTick;

  always_comb begin
    lastTick = (state == ST_LIT) && (dwellCnt == CNT_W'(DWELL_CYCLES - 1));
    nextIdx  = (scanIdx == IDX_W'(NUM_DIGITS - 1)) ? '0 : scanIdx + 1'b1;
    strobe.loadSeg = (state == ST_LOAD) || lastTick;
    strobe.darkOn  = lastTick;
    strobe.lightOn = (state == ST_BLANK);
    selIdx = lastTick ? nextIdx : scanIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LOAD;
      scanIdx  <= '0;
      dwellCnt <= '0;
    end else begin
      case (state)
        ST_LOAD: state <= ST_BLANK;
        ST_BLANK: begin
          state    <= ST_LIT;
          dwellCnt <= '0;
        end
        ST_LIT: begin
          if (lastTick) begin
            state    <= ST_BLANK;
            scanIdx  <= nextIdx;
            dwellCnt <= '0;
          end else begin
            dwellCnt <= dwellCnt + 1'b1;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  // dwell counter never runs past the programmed length
  assert_dwell_bound_R4: assert property (@(posedge clk) disable iff (rst)
    int'(dwellCnt) < DWELL_CYCLES);

  // scan index stays on a real digit
  assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
    int'(scanIdx) < NUM_DIGITS);

  // index only advances by one or wraps to zero
  assert_idx_step_R6: assert property (@(posedge clk) disable iff (rst)
    (scanIdx != $past(scanIdx)) |->
      ((scanIdx == '0) || (int'(scanIdx) == int'($past(scanIdx)) + 1)));

endmodule

// File: rtl/segscan_datapath.sv
`timescale 1ns/1ps
module segscan_datapath
  import segscan_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int SEG_W      = 8,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [IDX_W-1:0]      wrAddr,
  input  logic [SEG_W-1:0]      wrData,
  input  scanStrobe_t           strobe,
  input  logic [IDX_W-1:0]      selIdx,
  output logic [SEG_W-1:0]      segOut,
  output logic [NUM_DIGITS-1:0] cathN
);

  logic [SEG_W-1:0] segRegs [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    always_ff @(posedge clk) begin
      if (rst)
        segRegs[g] <= '0;
      else if (wrEn && (wrAddr == IDX_W'(g)))
        segRegs[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      segOut <= '0;
      cathN  <= '1;
    end else begin
      if (strobe.loadSeg)
        segOut <= segRegs[selIdx];
      if (strobe.darkOn)
        cathN <= '1;
      else if (strobe.lightOn)
        cathN <= ~(NUM_DIGITS'(1) << selIdx);
    end
  end

  // never more than one digit lit
  assert_single_digit_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cathN));

  // bus frozen while a digit is lit
  assert_bus_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (cathN != '1) |-> $stable(segOut));

  // a newly lit digit is always preceded by an all-dark cycle
  assert_dark_gap_R5: assert property (@(posedge clk) disable iff (rst)
    ((cathN != '1) && (cathN != $past(cathN))) |-> ($past(cathN) == '1));

endmodule

// File: rtl/seg_scan_driver.sv
`timescale 1ns/1ps
module seg_scan_driver
  import segscan_pkg::*;
#(
  parameter int NUM_DIGITS   = 4,
  parameter int SEG_W        = 8,
  parameter int DWELL_CYCLES = 50000,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [IDX_W-1:0]      wrAddr,
  input  logic [SEG_W-1:0]      wrData,
  output logic [SEG_W-1:0]      segOut,
  output logic [NUM_DIGITS-1:0] cathN
);

  scanStrobe_t      strobe;
  logic [IDX_W-1:0] selIdx;

  segscan_ctrl #(
    .NUM_DIGITS  (NUM_DIGITS),
    .DWELL_CYCLES(DWELL_CYCLES)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .selIdx(selIdx)
  );

  segscan_datapath #(
    .NUM_DIGITS(NUM_DIGITS),
    .SEG_W     (SEG_W)
  ) u_dp (
    .clk   (clk),
    .rst   (rst),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .strobe(strobe),
    .selIdx(selIdx),
    .segOut(segOut),
    .cathN (cathN)
  );

  // outputs while in reset (checked on the edge after)
  assert_reset_dark_R1: assert property (@(posedge clk)
    $past(rst) |-> ((cathN == '1) && (segOut == '0)));

endmodule

// File: tb/sim_seg_scan_driver.sv
`timescale 1ns/1ps
module sim_seg_scan_driver;

  localparam int N = 4;
  localparam int D = 6;
  localparam int P = D + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] segOut;
  logic [3:0] cathN;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  seg_scan_driver #(.NUM_DIGITS(N), .SEG_W(8), .DWELL_CYCLES(D)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .segOut(segOut), .cathN(cathN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-accurate expectation from the requirement timing
  int         k = 0;
  logic [7:0] mirror [N];
  logic [7:0] expSeg = '0;
  logic [3:0] expCath = '1;

  always @(posedge clk) begin
    #1;
    if (rst) begin
      k = 0;
      for (int i = 0; i < N; i++) mirror[i] = '0;
      expSeg = '0;
      expCath = '1;
      chk("R1 cathodes in reset", 32'(cathN), 32'hF);
      chk("R1 bus in reset", 32'(segOut), 32'h0);
    end else begin
      k++;
      if (k == 1) begin
        expSeg = mirror[0];
        expCath = '1;
      end else begin
        int m, d, r;
        m = k - 2;
        d = (m / P) % N;
        r = m % P;
        if (r < D) expCath = ~(4'b0001 << d);
        else begin
          expCath = '1;
          expSeg = mirror[(d + 1) % N];
        end
      end
      if (k <= 2) begin
        chk("R2 cathodes after release", 32'(cathN), 32'(expCath));
        chk("R2 bus after release", 32'(segOut), 32'(expSeg));
      end else begin
        chk("R3 R4 R5 R6 cathodes", 32'(cathN), 32'(expCath));
        chk("R5 R7 R8 bus", 32'(segOut), 32'(expSeg));
      end
      if (wrEn) mirror[wrAddr] = wrData;
    end
  end

  task automatic writeDigit(input int dig, input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'(dig); wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCath(input logic [3:0] v);
    int guard = 0;
    while (cathN !== v && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // digit patterns: byte i is digit i; bit 7 = decimal point
  localparam logic [31:0] VEC [6] = '{
    32'h4F5B063F, 32'h077D6D66, 32'h80FF7F6F,
    32'h01020408, 32'h10204080, 32'hAA55C3FF
  };

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // table walk: load a set, then see each digit on the bus (R9)
    for (int v = 0; v < 6; v++) begin
      for (int i = 0; i < N; i++) writeDigit(i, VEC[v][8*i +: 8]);
      repeat (2 * N * P) @(negedge clk);
      for (int i = 0; i < N; i++) begin
        waitCath(~(4'b0001 << i));
        chk("R9 pattern passed to anodes", 32'(segOut), 32'(VEC[v][8*i +: 8]));
      end
    end

    // R4 dwell length and R5 single dark cycle, R6 next digit
    begin
      int lit = 0;
      waitCath(4'b1111);
      waitCath(4'b1110);
      while (cathN === 4'b1110) begin
        lit++;
        @(negedge clk);
      end
      chk("R4 lit cycles of digit 0", 32'(lit), 32'(D));
      chk("R5 dark gap", 32'(cathN), 32'hF);
      @(negedge clk);
      chk("R6 digit 1 follows digit 0", 32'(cathN), 32'hD);
    end

    // R6 wrap from last digit to digit 0
    waitCath(4'b0111);
    while (cathN === 4'b0111) @(negedge clk);
    @(negedge clk);
    chk("R6 wrap to digit 0", 32'(cathN), 32'hE);

    // R8 write to the lit digit is deferred
    begin
      logic [7:0] held;
      waitCath(4'b1011);
      held = segOut;
      writeDigit(2, 8'hA5);
      chk("R8 lit digit unchanged after write", 32'(segOut), 32'(held));
      while (cathN === 4'b1011) @(negedge clk);
      waitCath(4'b1011);
      chk("R8 new pattern on next scan", 32'(segOut), 32'hA5);
    end

    // mid-scan reset clears outputs and stored patterns (R1)
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 dark after mid-run reset", 32'(cathN), 32'hF);
    rst = 1'b0;
    waitCath(4'b1011);
    chk("R1 patterns cleared", 32'(segOut), 32'h0);

    repeat (N * P) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule